// File: doc/BRIEF.md
# Transmit Packet Framer with FIFO

This block builds outgoing radio frames one bit at a time. The host writes payload bytes into a byte-wide transmit FIFO, sets up the framing fields on configuration inputs, and pulses a start command. The framer then sends a preamble, a sync word, optional header bytes, an optional length byte, a fixed count of payload bytes drawn from the FIFO, and an optional 16-bit CRC. It moves on by one bit for each pulse on the bit-strobe input, which the modulator downstream provides.

When a frame is finished, the framer returns to ready and latches a packet-sent status bit. It does not start again until the host issues a new start command. If the FIFO runs dry partway through the payload, the framer latches an underflow bit and drops back to ready without sending a CRC. Two FIFO fill-level comparisons give almost-full and almost-empty status. Every status bit is latched whatever its interrupt enable. The active-low interrupt pin reflects only the enabled bits.

Top module: `pkt_framer_tx`

## Requirements
- R1: After `tx_go` is accepted in ready, `tx_bit` shows the first frame bit. Each `bit_stb` pulse moves it to the next bit. Bytes go most significant bit first. The field order is preamble, sync, header, length, payload, CRC. The preamble bytes are 0xAA, so the first bit is a one.
- R2: The preamble is `cfg_pre`+1 bytes and the sync word is `cfg_sync_n`+1 bytes. The sync bytes are taken from `sync_word`, highest byte first. The header is `cfg_hdr_n` bytes (0..3), taken from `hdr_word` highest byte first. When `cfg_len_en` is 1, a single byte carrying `pkt_len` follows the header.
- R3: `crc_sel` picks the CRC: 1 gives polynomial 0x1021, 2 gives polynomial 0x8005, and 0 or 3 gives no CRC field. The CRC is seeded to 0xFFFF at each start and covers the header, length and payload bits. It is sent as 16 bits, most significant bit first.
- R4: Exactly `pkt_len` payload bytes are taken from the FIFO in write order. After the last bit of the frame, `ready` rises and status bit 0 (packet sent) is latched.
- R5: In ready, `tx_bit` is 0, `bit_stb` pulses have no effect, and no FIFO byte is consumed until the next `tx_go`.
- R6: If the FIFO is empty when a payload byte is needed, status bit 1 (underflow) is latched, no CRC is sent, `ready` rises and status bit 0 stays clear.
- R7: A `fifo_clr` pulse discards all stored bytes.
- R8: Status bit 2 is set while the FIFO level is greater than `af_thr`. Status bit 3 is set while the level is at most `ae_thr`.
- R9: Status bits latch whatever the value of `irq_en`. A pulse on `irq_clr` clears them, but a condition that is still true sets its bit again. `nirq` is low exactly when some status bit and its enable are both 1.
- R10: While `rst_n` is low, `ready` is 1, `tx_bit` is 0, the status is 0 and `nirq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one byte into the FIFO |
| wr_data | input | 8 | Byte to write |
| fifo_clr | input | 1 | Discard FIFO contents |
| tx_go | input | 1 | Start a frame (taken only in ready) |
| bit_stb | input | 1 | Advance the serial output by one bit |
| cfg_pre | input | 4 | Preamble bytes minus one |
| cfg_sync_n | input | 2 | Sync bytes minus one |
| sync_word | input | 32 | Sync pattern, highest byte first |
| cfg_hdr_n | input | 2 | Header byte count, 0..3 |
| hdr_word | input | 24 | Header bytes, highest byte first |
| cfg_len_en | input | 1 | Send the length byte |
| pkt_len | input | 8 | Payload byte count |
| crc_sel | input | 2 | CRC choice: 0 none, 1 0x1021, 2 0x8005, 3 none |
| af_thr | input | 6 | Almost-full threshold |
| ae_thr | input | 6 | Almost-empty threshold |
| irq_en | input | 4 | Interrupt enables, one per status bit |
| irq_clr | input | 1 | Clear latched status |
| tx_bit | output | 1 | Serial frame bit |
| ready | output | 1 | Idle, ready for a start command |
| irq_status | output | 4 | Latched status: 0 sent, 1 underflow, 2 almost full, 3 almost empty |
| nirq | output | 1 | Active-low interrupt |

## Verification
A field sequencer that skips, repeats or misorders a field puts a wrong bit on `tx_bit` within eight strobes of the fault. The bench compares every strobed bit against a frame it builds on its own, so such a fault shows up at once. A CRC register with a wrong seed or polynomial only shows in the last 16 bits of the frame. A FIFO pointer that is off by one shows as a wrong payload byte in the next frame that reads it. A status latch or enable fault shows on `irq_status` and `nirq` one cycle after the event that should set it.

// File: rtl/txf_pkg.sv
package txf_pkg;
    // Frame fields in transmit order; the order drives field sequencing.
    typedef enum logic [2:0] {
        F_PRE  = 3'd0,
        F_SYNC = 3'd1,
        F_HDR  = 3'd2,
        F_LEN  = 3'd3,
        F_PAY  = 3'd4,
        F_CRC  = 3'd5,
        F_DONE = 3'd6
    } fld_t;

    localparam int          NSRC       = 4;
    localparam int          ST_SENT    = 0;
    localparam int          ST_UFLOW   = 1;
    localparam int          ST_AFULL   = 2;
    localparam int          ST_AEMPTY  = 3;
    localparam logic [15:0] POLY_A     = 16'h1021;
    localparam logic [15:0] POLY_B     = 16'h8005;
    localparam logic [7:0]  PRE_BYTE   = 8'hAA;
endpackage

// File: rtl/txf_fifo.sv
// Byte FIFO for the transmit payload.
// Does: stores host bytes, gives a combinational head byte, reports its level.
// Assumes: a write when full is dropped; a pop when empty is never issued; clear wins.
module txf_fifo #(
    parameter int DW = 8,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic [AW:0]   level,
    output logic          empty
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_wr, do_rd;

    assign do_wr   = wr_en && (level != (AW+1)'(DEPTH));
    assign do_rd   = rd_en && !empty;
    assign empty   = (level == '0);
    assign rd_data = mem[rp];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wr_data;
    end

    // Pointer and level update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_wr) wp <= wp + 1'b1;
            if (do_rd) rp <= rp + 1'b1;
            level <= level + (AW+1)'(do_wr) - (AW+1)'(do_rd);
        end
    end
endmodule

// File: rtl/txf_crc.sv
// Serial 16-bit CRC.
// Does: one bit per step, MSB-first feedback, polynomial chosen by sel.
// Assumes: seed has priority over step; crc_d is the value after this cycle.
module txf_crc #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seed,
    input  logic          step,
    input  logic          din,
    input  logic [1:0]    sel,
    output logic          crc_on,
    output logic [CW-1:0] crc_q,
    output logic [CW-1:0] crc_d
);
    import txf_pkg::*;

    logic [CW-1:0] poly;

    // Polynomial select.
    always_comb begin
        case (sel)
            2'd1:    poly = POLY_A;
            2'd2:    poly = POLY_B;
            default: poly = '0;
        endcase
    end

    assign crc_on = (sel == 2'd1) || (sel == 2'd2);

    // Next value of the shift register.
    always_comb begin
        crc_d = crc_q;
        if (seed)
            crc_d = '1;
        else if (step)
            crc_d = {crc_q[CW-2:0], 1'b0} ^ ((crc_q[CW-1] ^ din) ? poly : '0);
    end

    // Register.
    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '1;
        else        crc_q <= crc_d;
    end
endmodule

// File: rtl/txf_irq.sv
// Interrupt status latch.
// Does: latches set pulses or levels, clears on request, drives the active-low pin.
// Assumes: a set in the same cycle as a clear wins.
module txf_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] en,
    input  logic         clr,
    output logic [N-1:0] status,
    output logic         nirq
);
    // Status latch.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (clr ? '0 : status) | set;
    end

    assign nirq = ~|(status & en);
endmodule

// File: rtl/pkt_framer_tx.sv
// Transmit packet framer.
// Does: sequences preamble, sync, header, length, payload and CRC bytes onto a
//       strobed serial output, then returns to ready with a sent status.
// Assumes: configuration inputs are held stable while a frame is in flight.
module pkt_framer_tx
    import txf_pkg::*;
#(
    parameter int AW       = 6,
    parameter int LW       = 8,
    parameter int SYNC_MAX = 4,
    parameter int HDR_MAX  = 3,
    parameter int THW      = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [7:0]                   wr_data,
    input  logic                         fifo_clr,
    input  logic                         tx_go,
    input  logic                         bit_stb,
    input  logic [3:0]                   cfg_pre,
    input  logic [$clog2(SYNC_MAX)-1:0]  cfg_sync_n,
    input  logic [8*SYNC_MAX-1:0]        sync_word,
    input  logic [$clog2(HDR_MAX+1)-1:0] cfg_hdr_n,
    input  logic [8*HDR_MAX-1:0]         hdr_word,
    input  logic                         cfg_len_en,
    input  logic [LW-1:0]                pkt_len,
    input  logic [1:0]                   crc_sel,
    input  logic [THW-1:0]               af_thr,
    input  logic [THW-1:0]               ae_thr,
    input  logic [NSRC-1:0]              irq_en,
    input  logic                         irq_clr,
    output logic                         tx_bit,
    output logic                         ready,
    output logic [NSRC-1:0]              irq_status,
    output logic                         nirq
);
    localparam int SYNC_W = 8 * SYNC_MAX;
    localparam int HDR_W  = 8 * HDR_MAX;
    localparam int CNTW   = LW + 1;

    fld_t        fld, ld_f, nxt_f;
    logic [LW-1:0] idx, ld_i;
    logic [CNTW-1:0] cur_len;
    logic [2:0]  bitc;
    logic [7:0]  shreg, ld_byte;
    logic        busy, start, adv, byte_end, fld_last;
    logic        underrun, pop, done, crc_on;
    logic [6:0]  present;
    logic [7:0]  head;
    logic [AW:0] level;
    logic        empty;
    logic [15:0] crc_q, crc_d;
    logic [NSRC-1:0] set_v;

    assign start    = tx_go && !busy;
    assign adv      = busy && bit_stb;
    assign byte_end = adv && (bitc == 3'd7);
    assign ready    = !busy;
    assign tx_bit   = busy && shreg[7];

    // Length in bytes of the field being sent.
    always_comb begin
        case (fld)
            F_PRE:   cur_len = CNTW'(cfg_pre) + 1'b1;
            F_SYNC:  cur_len = CNTW'(cfg_sync_n) + 1'b1;
            F_HDR:   cur_len = CNTW'(cfg_hdr_n);
            F_LEN:   cur_len = CNTW'(1);
            F_PAY:   cur_len = CNTW'(pkt_len);
            F_CRC:   cur_len = CNTW'(2);
            default: cur_len = '0;
        endcase
    end

    // Which fields carry bytes in this frame; F_DONE never does.
    assign present = {1'b0, crc_on, (pkt_len != '0), cfg_len_en,
                      (cfg_hdr_n != '0), 1'b1, 1'b1};

    // First non-empty field after the current one.
    always_comb begin
        nxt_f = F_DONE;
        for (int k = 6; k >= 0; k--) begin
            if (k > int'(fld) && present[k]) nxt_f = fld_t'(k);
        end
    end

    assign fld_last = ({1'b0, idx} + 1'b1) >= cur_len;
    assign ld_f     = fld_last ? nxt_f : fld;
    assign ld_i     = fld_last ? '0 : idx + 1'b1;

    // Byte to load at the next byte boundary.
    always_comb begin
        ld_byte = '0;
        case (ld_f)
            F_PRE:  ld_byte = PRE_BYTE;
            F_SYNC: begin
                for (int k = 0; k < SYNC_MAX; k++)
                    if (ld_i == LW'(k)) ld_byte = sync_word[SYNC_W-8-8*k +: 8];
            end
            F_HDR: begin
                for (int k = 0; k < HDR_MAX; k++)
                    if (ld_i == LW'(k)) ld_byte = hdr_word[HDR_W-8-8*k +: 8];
            end
            F_LEN:  ld_byte = 8'(pkt_len);
            F_PAY:  ld_byte = head;
            F_CRC:  ld_byte = (ld_i == '0) ? crc_d[15:8] : crc_q[7:0];
            default: ld_byte = '0;
        endcase
    end

    assign underrun = byte_end && (ld_f == F_PAY) && empty;
    assign pop      = byte_end && (ld_f == F_PAY) && !empty;
    assign done     = byte_end && (ld_f == F_DONE);

    // Frame sequencer and bit shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            fld   <= F_PRE;
            idx   <= '0;
            bitc  <= '0;
            shreg <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            fld   <= F_PRE;
            idx   <= '0;
            bitc  <= '0;
            shreg <= PRE_BYTE;
        end else if (byte_end) begin
            busy  <= !(underrun || done);
            fld   <= ld_f;
            idx   <= ld_i;
            bitc  <= '0;
            shreg <= ld_byte;
        end else if (adv) begin
            bitc  <= bitc + 1'b1;
            shreg <= {shreg[6:0], 1'b0};
        end
    end

    txf_fifo #(.DW(8), .AW(AW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(pop), .rd_data(head), .level(level), .empty(empty)
    );

    txf_crc #(.CW(16)) u_crc (
        .clk(clk), .rst_n(rst_n), .seed(start),
        .step(adv && (fld == F_HDR || fld == F_LEN || fld == F_PAY)),
        .din(shreg[7]), .sel(crc_sel), .crc_on(crc_on), .crc_q(crc_q), .crc_d(crc_d)
    );

    // Status sources: events and level comparisons.
    always_comb begin
        set_v            = '0;
        set_v[ST_SENT]   = done;
        set_v[ST_UFLOW]  = underrun;
        set_v[ST_AFULL]  = level > (AW+1)'(af_thr);
        set_v[ST_AEMPTY] = level <= (AW+1)'(ae_thr);
    end

    txf_irq #(.N(NSRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(set_v), .en(irq_en), .clr(irq_clr),
        .status(irq_status), .nirq(nirq)
    );
endmodule

// File: rtl/txf_checker.sv
// Port-level properties of the framer; attached to every framer instance by bind.
module txf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_go,
    input logic       bit_stb,
    input logic       tx_bit,
    input logic       ready,
    input logic [3:0] irq_status,
    input logic [3:0] irq_en,
    input logic       nirq
);
    // R1: an accepted start shows the leading preamble one.
    assert_start_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && tx_go) |=> (!ready && tx_bit));

    // R1: without a strobe the serial bit holds during a frame.
    assert_hold_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !bit_stb) |=> $stable(tx_bit));

    // R5: idle output is quiet.
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !tx_bit);

    // R4: packet sent appears only as a frame ends.
    assert_sent_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[0]) |-> ($past(!ready) && ready));

    // R6: an underflow leaves the framer ready.
    assert_uflow_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_status[1]) |-> ready);

    // R9: with every enable off the pin stays high.
    assert_masked_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 4'b0000) |-> nirq);
endmodule

bind pkt_framer_tx txf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tx_go(tx_go), .bit_stb(bit_stb), .tx_bit(tx_bit),
    .ready(ready), .irq_status(irq_status), .irq_en(irq_en), .nirq(nirq)
);

// File: tb/pkt_framer_tx_test.sv
module pkt_framer_tx_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        fifo_clr = 1'b0;
    logic        tx_go = 1'b0;
    logic        bit_stb = 1'b0;
    logic [3:0]  cfg_pre = '0;
    logic [1:0]  cfg_sync_n = '0;
    logic [31:0] sync_word = '0;
    logic [1:0]  cfg_hdr_n = '0;
    logic [23:0] hdr_word = '0;
    logic        cfg_len_en = 1'b0;
    logic [7:0]  pkt_len = '0;
    logic [1:0]  crc_sel = '0;
    logic [5:0]  af_thr = 6'h37;
    logic [5:0]  ae_thr = 6'h04;
    logic [3:0]  irq_en = '0;
    logic        irq_clr = 1'b0;
    logic        tx_bit, ready, nirq;
    logic [3:0]  irq_status;

    int n_cmp = 0;
    int n_bad = 0;
    int bit_no = 0;
    logic exp_q[$];
    logic [7:0] byte_q[$];

    always #5 clk = ~clk;

    pkt_framer_tx uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .fifo_clr(fifo_clr),
        .tx_go(tx_go), .bit_stb(bit_stb), .cfg_pre(cfg_pre), .cfg_sync_n(cfg_sync_n),
        .sync_word(sync_word), .cfg_hdr_n(cfg_hdr_n), .hdr_word(hdr_word),
        .cfg_len_en(cfg_len_en), .pkt_len(pkt_len), .crc_sel(crc_sel), .af_thr(af_thr),
        .ae_thr(ae_thr), .irq_en(irq_en), .irq_clr(irq_clr), .tx_bit(tx_bit),
        .ready(ready), .irq_status(irq_status), .nirq(nirq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: each strobed bit is compared against the scoreboard queue (R1/R2/R3).
    always @(negedge clk) begin
        if (bit_stb) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R1 bit %0d: actual %0b expected none", bit_no, tx_bit);
            end else begin
                logic e;
                e = exp_q.pop_front();
                if (tx_bit !== e) begin
                    n_bad++;
                    $display("FAIL R1/R2/R3 bit %0d: actual %0b expected %0b", bit_no, tx_bit, e);
                end
            end
            bit_no++;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic pulse_clr_irq();
        irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        wr_en = 1'b1; wr_data = b; tick(); wr_en = 1'b0;
        byte_q.push_back(b);
    endtask

    task automatic strobe(input int gap);
        bit_stb = 1'b1; tick(); bit_stb = 1'b0;
        repeat (gap) tick();
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b,
                                            input logic [15:0] poly);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = r[15] ^ b[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ poly;
        end
        return r;
    endfunction

    // Driver: builds the expected frame, starts it and strobes every bit.
    task automatic run_pkt(input int gap);
        logic [15:0] c, poly;
        logic        uf, crc_on;
        int          nbits;
        c      = 16'hFFFF;
        poly   = (crc_sel == 2'd1) ? 16'h1021 : 16'h8005;
        crc_on = (crc_sel == 2'd1) || (crc_sel == 2'd2);
        uf     = 1'b0;
        for (int i = 0; i <= int'(cfg_pre); i++) push_byte(8'hAA);
        for (int i = 0; i <= int'(cfg_sync_n); i++) push_byte(sync_word[24-8*i +: 8]);
        for (int i = 0; i < int'(cfg_hdr_n); i++) begin
            push_byte(hdr_word[16-8*i +: 8]);
            c = crc_upd(c, hdr_word[16-8*i +: 8], poly);
        end
        if (cfg_len_en) begin
            push_byte(pkt_len);
            c = crc_upd(c, pkt_len, poly);
        end
        for (int i = 0; i < int'(pkt_len); i++) begin
            if (!uf) begin
                if (byte_q.size() == 0) uf = 1'b1;
                else begin
                    logic [7:0] b;
                    b = byte_q.pop_front();
                    push_byte(b);
                    c = crc_upd(c, b, poly);
                end
            end
        end
        if (!uf && crc_on) begin
            push_byte(c[15:8]);
            push_byte(c[7:0]);
        end
        nbits = exp_q.size();
        pulse_clr_irq();
        tx_go = 1'b1; tick(); tx_go = 1'b0;
        chk("R1 busy after start", {31'b0, ready}, 32'd0);
        repeat (nbits) strobe(gap);
        chk("R4 ready after frame", {31'b0, ready}, 32'd1);
        chk("R4 sent status", {31'b0, irq_status[0]}, {31'b0, !uf});
        chk("R6 underflow status", {31'b0, irq_status[1]}, {31'b0, uf});
        chk("R5 idle tx_bit", {31'b0, tx_bit}, 32'd0);
        chk("R1 all bits consumed", exp_q.size(), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) tick();
        // R10: reset state.
        chk("R10 ready", {31'b0, ready}, 32'd1);
        chk("R10 tx_bit", {31'b0, tx_bit}, 32'd0);
        chk("R10 status", {28'b0, irq_status}, 32'd0);
        chk("R10 nirq", {31'b0, nirq}, 32'd1);
        rst_n = 1'b1;
        repeat (2) tick();
        // R8/R9: empty FIFO latches almost-empty even with enables off.
        chk("R8 almost empty", {31'b0, irq_status[3]}, 32'd1);
        chk("R9 masked pin", {31'b0, nirq}, 32'd1);

        // Frame A: 1 preamble, 2 sync, 1 header, length, 3 payload, CRC 0x1021.
        wr(8'h01); wr(8'hC3); wr(8'h7E);
        cfg_pre = 4'd0; cfg_sync_n = 2'd1; sync_word = 32'h2DD4_0000;
        cfg_hdr_n = 2'd1; hdr_word = 24'h5A0000; cfg_len_en = 1'b1;
        pkt_len = 8'd3; crc_sel = 2'd1;
        run_pkt(0);

        // R9: enable the sent bit, then clear it.
        irq_en = 4'b0001; tick();
        chk("R9 enabled pin low", {31'b0, nirq}, 32'd0);
        pulse_clr_irq(); tick();
        chk("R9 clear sent", {31'b0, irq_status[0]}, 32'd0);
        chk("R9 pin released", {31'b0, nirq}, 32'd1);
        irq_en = 4'b0000;

        // R5: strobes while ready do nothing and consume nothing.
        wr(8'h11); wr(8'h22);
        for (int i = 0; i < 10; i++) exp_q.push_back(1'b0);
        repeat (10) strobe(1);
        chk("R5 still ready", {31'b0, ready}, 32'd1);

        // Frame B: 3 preamble, 4 sync, no header, no length, 4 payload, CRC 0x8005.
        wr(8'h33); wr(8'h44);
        cfg_pre = 4'd2; cfg_sync_n = 2'd3; sync_word = 32'hDEADBEEF;
        cfg_hdr_n = 2'd0; cfg_len_en = 1'b0; pkt_len = 8'd4; crc_sel = 2'd2;
        run_pkt(2);

        // Frame C: 3 header bytes, length, 1 payload, no CRC (R3 sel 3).
        wr(8'h99);
        cfg_pre = 4'd1; cfg_sync_n = 2'd0; sync_word = 32'hB7000000;
        cfg_hdr_n = 2'd3; hdr_word = 24'hA1B2C3; cfg_len_en = 1'b1;
        pkt_len = 8'd1; crc_sel = 2'd3;
        run_pkt(1);

        // R6: underflow after 2 of 4 payload bytes.
        wr(8'hE1); wr(8'h5F);
        cfg_hdr_n = 2'd1; hdr_word = 24'h0F0000; pkt_len = 8'd4; crc_sel = 2'd1;
        run_pkt(0);

        // R7: cleared bytes are not sent.
        wr(8'h10); wr(8'h20); wr(8'h30);
        fifo_clr = 1'b1; tick(); fifo_clr = 1'b0;
        byte_q.delete();
        wr(8'h77);
        cfg_hdr_n = 2'd0; cfg_len_en = 1'b0; pkt_len = 8'd1; crc_sel = 2'd2;
        run_pkt(0);

        // R8: almost full above 0x37 bytes, almost empty clear above 4.
        for (int i = 0; i < 55; i++) wr(8'(i));
        pulse_clr_irq(); tick();
        chk("R8 not almost full at 55", {31'b0, irq_status[2]}, 32'd0);
        chk("R8 not almost empty at 55", {31'b0, irq_status[3]}, 32'd0);
        wr(8'hFF); tick();
        chk("R8 almost full at 56", {31'b0, irq_status[2]}, 32'd1);
        chk("R9 latched while masked", {31'b0, nirq}, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule